// File: doc/BRIEF.md
# Layered Video Overlay Mixer

The mixer composites one foreground video layer onto a background picture. The two streams arrive as valid/ready pixel streams in raster order, each frame framed by start-of-packet and end-of-packet markers. The background frame size and the foreground frame size are fixed by parameters. The mixer sends out one stream with the same framing as the background, and emits one output pixel for every background pixel. A foreground pixel replaces the background pixel beneath it when the layer is shown. The layer's top-left corner sits at a programmable column and line offset from the top-left corner of the background.

A small word-addressed register port sets up the block. It holds a run-enable bit, a running flag, the two layer offsets and a three-valued layer mode. In "off" mode the foreground input is never read. In "show" mode the layer is drawn. In "sink" mode the foreground frame is pulled in and discarded.

All layer settings are captured when a frame begins. Software may therefore rewrite them at any time without tearing the picture. Clearing the run-enable bit lets the current frame finish and stops the block before the next one.

Top module: `ovl_mixer`

## Requirements
- R1: After reset the output valid, the background ready and the foreground ready are low, and every register address reads zero.
- R2: Address 0 bit 0 is the run-enable bit, and all other bits of address 0 read zero. Addresses 2 and 3 hold the column and line offsets. Address 4 holds the layer mode: 0 = off, 1 = show, 2 = sink, and a written 3 is stored as 0. Unused addresses read zero.
- R3: Address 1 bit 0 reads 1 while a frame is being processed and reads 0 when the block is idle.
- R4: A frame starts only while run-enable is 1. Clearing run-enable during a frame lets that frame complete in full. The background ready then stays low.
- R5: In show mode, the output pixel at column x, line y is foreground pixel number (y-Y)*FG_W + (x-X) when X <= x < X+FG_W and Y <= y < Y+FG_H. Every other output pixel is the background pixel.
- R6: In sink mode, all FG_W*FG_H foreground pixels are accepted and the output equals the background.
- R7: In off mode, the foreground ready stays low for the whole frame and the output equals the background.
- R8: Offsets and mode are sampled when a frame starts. Writes made during a frame do not change that frame.
- R9: Foreground pixels whose placed position lies right of or below the background are accepted and dropped. The following frame still starts and mixes correctly.
- R10: While the output valid is high and the output ready is low, the output data and markers hold. No pixel is lost or repeated.
- R11: The output start marker is high only with pixel 0, and the end marker only with pixel BG_W*BG_H-1. The two markers are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| reg_cs | input | 1 | Register access select |
| reg_wr | input | 1 | Register write strobe (qualified by reg_cs) |
| reg_addr | input | REG_AW | Register word address |
| reg_wdata | input | REG_DW | Register write data |
| reg_rdata | output | REG_DW | Register read data (combinational, zero when not selected) |
| bg_data | input | PIX_W | Background pixel |
| bg_valid | input | 1 | Background pixel valid |
| bg_sop | input | 1 | Background start-of-frame marker |
| bg_eop | input | 1 | Background end-of-frame marker |
| bg_ready | output | 1 | Background pixel accepted when high with bg_valid |
| fg_data | input | PIX_W | Foreground pixel |
| fg_valid | input | 1 | Foreground pixel valid |
| fg_sop | input | 1 | Foreground start-of-frame marker |
| fg_eop | input | 1 | Foreground end-of-frame marker |
| fg_ready | output | 1 | Foreground pixel accepted when high with fg_valid |
| out_data | output | PIX_W | Composited pixel |
| out_valid | output | 1 | Composited pixel valid |
| out_sop | output | 1 | Output start-of-frame marker |
| out_eop | output | 1 | Output end-of-frame marker |
| out_ready | input | 1 | Downstream ready |

## Verification
The bench aims at placements that clip the layer on the right and bottom edges. A mixer that waits for clipped pixels to be displayed deadlocks, and one that forgets to drain them shifts every later foreground pixel. Each frame rewrites the offsets and the mode partway through, so a design that follows live registers instead of sampled ones tears the picture. The output is stalled in a repeating pattern, which exposes dropped or doubled pixels and misplaced markers. Off and sink modes are checked through the foreground ready and through a pure-background picture, and run-enable is cleared mid-frame to show that the frame still completes and the block then stays idle.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int OVL_OFS_W = 12;

  localparam int ADR_CTRL  = 0;
  localparam int ADR_STAT  = 1;
  localparam int ADR_LX    = 2;
  localparam int ADR_LY    = 3;
  localparam int ADR_LMODE = 4;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_SHOW = 2'd1,
    MODE_SINK = 2'd2
  } layer_mode_e;

  typedef struct packed {
    logic [OVL_OFS_W-1:0] x;
    logic [OVL_OFS_W-1:0] y;
    layer_mode_e          mode;
  } layer_cfg_t;
endpackage

// File: rtl/ovl_regs.sv
module ovl_regs
  import ovl_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          running,
  output logic [DW-1:0] rdata,
  output logic          go,
  output layer_cfg_t    cfg
);
  logic       go_n;
  layer_cfg_t cfg_n;
  logic       wr_en;

  assign wr_en = cs & wr;

  always_comb begin
    go_n  = go;
    cfg_n = cfg;
    if (wr_en) begin
      case (int'(addr))
        ADR_CTRL:  go_n = wdata[0];
        ADR_LX:    cfg_n.x = wdata[OVL_OFS_W-1:0];
        ADR_LY:    cfg_n.y = wdata[OVL_OFS_W-1:0];
        ADR_LMODE: cfg_n.mode = (wdata[1:0] == 2'd3) ? MODE_OFF : layer_mode_e'(wdata[1:0]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go  <= 1'b0;
      cfg <= '{x: '0, y: '0, mode: MODE_OFF};
    end else if (wr_en) begin
      go  <= go_n;
      cfg <= cfg_n;
    end
  end

  always_comb begin
    rdata = '0;
    if (cs) begin
      case (int'(addr))
        ADR_CTRL:  rdata[0] = go;
        ADR_STAT:  rdata[0] = running;
        ADR_LX:    rdata[OVL_OFS_W-1:0] = cfg.x;
        ADR_LY:    rdata[OVL_OFS_W-1:0] = cfg.y;
        ADR_LMODE: rdata[1:0] = cfg.mode;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ovl_fg_track.sv
module ovl_fg_track
  import ovl_pkg::*;
#(
  parameter int BG_W = 8,
  parameter int BG_H = 5,
  parameter int FG_W = 3,
  parameter int FG_H = 2,
  localparam int XW  = OVL_OFS_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  layer_mode_e   start_mode,
  input  layer_cfg_t    cfg,
  input  logic          fg_valid,
  input  logic [XW-1:0] bg_x,
  input  logic [XW-1:0] bg_y,
  input  logic          bg_take,
  output logic          fg_ready,
  output logic          fg_match,
  output logic          fg_pend
);
  localparam int FXW = (FG_W > 1) ? $clog2(FG_W) : 1;
  localparam int FYW = (FG_H > 1) ? $clog2(FG_H) : 1;

  logic [FXW-1:0] fx, fx_n;
  logic [FYW-1:0] fy, fy_n;
  logic           pend_n;
  logic [XW-1:0]  px, py;
  logic           off_frame;
  logic           acc;
  logic           last;

  assign px        = XW'(cfg.x) + XW'(fx);
  assign py        = XW'(cfg.y) + XW'(fy);
  assign off_frame = (px >= XW'(BG_W)) || (py >= XW'(BG_H));
  assign fg_match  = fg_pend && !off_frame && (px == bg_x) && (py == bg_y);
  assign fg_ready  = fg_pend && ((cfg.mode == MODE_SINK) ||
                     ((cfg.mode == MODE_SHOW) && (off_frame || (fg_match && bg_take))));
  assign acc       = fg_valid && fg_ready;
  assign last      = (fx == FXW'(FG_W - 1)) && (fy == FYW'(FG_H - 1));

  always_comb begin
    fx_n   = fx;
    fy_n   = fy;
    pend_n = fg_pend;
    if (start) begin
      fx_n   = '0;
      fy_n   = '0;
      pend_n = (start_mode != MODE_OFF);
    end else if (acc) begin
      if (last) begin
        pend_n = 1'b0;
        fx_n   = '0;
        fy_n   = '0;
      end else if (fx == FXW'(FG_W - 1)) begin
        fx_n = '0;
        fy_n = fy + 1'b1;
      end else begin
        fx_n = fx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fx      <= '0;
      fy      <= '0;
      fg_pend <= 1'b0;
    end else if (start || acc) begin
      fx      <= fx_n;
      fy      <= fy_n;
      fg_pend <= pend_n;
    end
  end
endmodule

// File: rtl/ovl_out_stage.sv
module ovl_out_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] d,
  input  logic          d_sop,
  input  logic          d_eop,
  input  logic          o_ready,
  output logic          can_load,
  output logic          o_valid,
  output logic [DW-1:0] o_data,
  output logic          o_sop,
  output logic          o_eop
);
  logic vld_n;
  logic upd;

  assign can_load = !o_valid || o_ready;
  assign upd      = load || (o_valid && o_ready);
  assign vld_n    = load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_data  <= '0;
      o_sop   <= 1'b0;
      o_eop   <= 1'b0;
    end else if (upd) begin
      o_valid <= vld_n;
      if (load) begin
        o_data <= d;
        o_sop  <= d_sop;
        o_eop  <= d_eop;
      end
    end
  end
endmodule

// File: rtl/ovl_mixer.sv
module ovl_mixer
  import ovl_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int BG_W   = 8,
  parameter int BG_H   = 5,
  parameter int FG_W   = 3,
  parameter int FG_H   = 2,
  parameter int REG_AW = 3,
  parameter int REG_DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_cs,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic [PIX_W-1:0]  bg_data,
  input  logic              bg_valid,
  input  logic              bg_sop,
  input  logic              bg_eop,
  output logic              bg_ready,
  input  logic [PIX_W-1:0]  fg_data,
  input  logic              fg_valid,
  input  logic              fg_sop,
  input  logic              fg_eop,
  output logic              fg_ready,
  output logic [PIX_W-1:0]  out_data,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  input  logic              out_ready
);
  localparam int XW  = OVL_OFS_W + 1;
  localparam int BXW = (BG_W > 1) ? $clog2(BG_W) : 1;
  localparam int BYW = (BG_H > 1) ? $clog2(BG_H) : 1;

  logic           go;
  layer_cfg_t     cfg_reg, cfg_q;
  logic           run_q, run_n;
  logic [BXW-1:0] bx, bx_n;
  logic [BYW-1:0] by, by_n;
  logic           frame_start;
  logic           fg_pend, fg_match;
  logic           can_load;
  logic           in_rect, need_fg;
  logic           bg_acc, bg_take;
  logic           first_pix, last_pix;
  logic [XW-1:0]  bxe, bye;
  logic [1:0]     cur_mode;
  logic           fg_marks_unused;

  assign fg_marks_unused = fg_sop ^ fg_eop ^ bg_sop ^ bg_eop;
  assign cur_mode        = cfg_q.mode;

  ovl_regs #(.AW(REG_AW), .DW(REG_DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cs(reg_cs), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .running(run_q), .rdata(reg_rdata), .go(go), .cfg(cfg_reg)
  );

  assign frame_start = !run_q && go && !fg_pend;

  assign bxe     = XW'(bx);
  assign bye     = XW'(by);
  assign in_rect = (bxe >= XW'(cfg_q.x)) && (bxe < XW'(cfg_q.x) + XW'(FG_W)) &&
                   (bye >= XW'(cfg_q.y)) && (bye < XW'(cfg_q.y) + XW'(FG_H));
  assign need_fg = (cfg_q.mode == MODE_SHOW) && in_rect;

  assign bg_ready  = run_q && can_load && (!need_fg || (fg_valid && fg_match));
  assign bg_acc    = bg_valid && bg_ready;
  assign bg_take   = bg_acc && need_fg;
  assign first_pix = (bx == '0) && (by == '0);
  assign last_pix  = (bx == BXW'(BG_W - 1)) && (by == BYW'(BG_H - 1));

  ovl_fg_track #(.BG_W(BG_W), .BG_H(BG_H), .FG_W(FG_W), .FG_H(FG_H)) u_fg (
    .clk(clk), .rst_n(rst_n), .start(frame_start), .start_mode(cfg_reg.mode),
    .cfg(cfg_q), .fg_valid(fg_valid), .bg_x(bxe), .bg_y(bye), .bg_take(bg_take),
    .fg_ready(fg_ready), .fg_match(fg_match), .fg_pend(fg_pend)
  );

  ovl_out_stage #(.DW(PIX_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(bg_acc),
    .d(need_fg ? fg_data : bg_data), .d_sop(first_pix), .d_eop(last_pix),
    .o_ready(out_ready), .can_load(can_load), .o_valid(out_valid),
    .o_data(out_data), .o_sop(out_sop), .o_eop(out_eop)
  );

  always_comb begin
    run_n = run_q;
    bx_n  = bx;
    by_n  = by;
    if (frame_start) begin
      run_n = 1'b1;
      bx_n  = '0;
      by_n  = '0;
    end else if (bg_acc) begin
      if (last_pix) begin
        run_n = 1'b0;
        bx_n  = '0;
        by_n  = '0;
      end else if (bx == BXW'(BG_W - 1)) begin
        bx_n = '0;
        by_n = by + 1'b1;
      end else begin
        bx_n = bx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      bx    <= '0;
      by    <= '0;
    end else if (frame_start || bg_acc) begin
      run_q <= run_n;
      bx    <= bx_n;
      by    <= by_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{x: '0, y: '0, mode: MODE_OFF};
    end else if (frame_start) begin
      cfg_q <= cfg_reg;
    end
  end
endmodule

// File: rtl/ovl_mixer_chk.sv
module ovl_mixer_chk #(
  parameter int PIX_W  = 8,
  parameter int REG_AW = 3,
  parameter int REG_DW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PIX_W-1:0]  out_data,
  input logic              out_sop,
  input logic              out_eop,
  input logic              fg_ready,
  input logic              bg_ready,
  input logic              run_q,
  input logic [1:0]        cur_mode,
  input logic              reg_cs,
  input logic [REG_AW-1:0] reg_addr,
  input logic [REG_DW-1:0] reg_rdata
);
  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));

  a_r11_marks_apart: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_sop && out_eop));

  a_r7_off_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 2'd0) |-> !fg_ready);

  a_r4_idle_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !bg_ready);

  a_r2_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_cs && reg_addr == '0) |-> (reg_rdata[REG_DW-1:1] == '0));
endmodule

bind ovl_mixer ovl_mixer_chk #(.PIX_W(PIX_W), .REG_AW(REG_AW), .REG_DW(REG_DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop), .fg_ready(fg_ready),
  .bg_ready(bg_ready), .run_q(run_q), .cur_mode(cur_mode), .reg_cs(reg_cs),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/ovl_mixer_bench.sv
`timescale 1ns/100ps
module ovl_mixer_bench;
  localparam int PIX_W = 8;
  localparam int BG_W = 8, BG_H = 5, FG_W = 3, FG_H = 2;
  localparam int NPIX = BG_W * BG_H;
  localparam int NFG  = FG_W * FG_H;
  localparam int NV   = 7;
  localparam int VX[NV] = '{0, 2, 6, 7, 1, 3, 5};
  localparam int VY[NV] = '{0, 1, 4, 0, 2, 1, 3};
  localparam int VM[NV] = '{1, 1, 1, 1, 2, 0, 1};

  logic clk, rst_n;
  logic reg_cs, reg_wr;
  logic [2:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [PIX_W-1:0] bg_data, fg_data, out_data;
  logic bg_valid, bg_sop, bg_eop, bg_ready;
  logic fg_valid, fg_sop, fg_eop, fg_ready;
  logic out_valid, out_sop, out_eop, out_ready;

  int checks, errors;
  logic col_done;

  ovl_mixer u_ovl_mixer (
    .clk(clk), .rst_n(rst_n), .reg_cs(reg_cs), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bg_data(bg_data), .bg_valid(bg_valid),
    .bg_sop(bg_sop), .bg_eop(bg_eop), .bg_ready(bg_ready), .fg_data(fg_data),
    .fg_valid(fg_valid), .fg_sop(fg_sop), .fg_eop(fg_eop), .fg_ready(fg_ready),
    .out_data(out_data), .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
    .out_ready(out_ready)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_cs = 1'b1; reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_cs = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic reg_read(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_cs = 1'b1; reg_wr = 1'b0; reg_addr = 3'(a);
    #1 d = reg_rdata;
    @(negedge clk);
    reg_cs = 1'b0;
  endtask

  task automatic drive_bg();
    for (int i = 0; i < NPIX; i++) begin
      @(negedge clk);
      bg_valid = 1'b1; bg_data = PIX_W'(8'h80 + i);
      bg_sop = (i == 0); bg_eop = (i == NPIX - 1);
      #1;
      while (!bg_ready) begin
        @(negedge clk); #1;
      end
    end
    @(negedge clk);
    bg_valid = 1'b0; bg_sop = 1'b0; bg_eop = 1'b0;
  endtask

  task automatic drive_fg();
    for (int i = 0; i < NFG; i++) begin
      @(negedge clk);
      fg_valid = 1'b1; fg_data = PIX_W'(8'h40 + i);
      fg_sop = (i == 0); fg_eop = (i == NFG - 1);
      #1;
      while (!fg_ready) begin
        @(negedge clk); #1;
      end
    end
    @(negedge clk);
    fg_valid = 1'b0; fg_sop = 1'b0; fg_eop = 1'b0;
  endtask

  task automatic watch_fg_off();
    int seen;
    seen = 0;
    while (!col_done) begin
      @(negedge clk);
      fg_valid = 1'b1; fg_data = 8'h55; fg_sop = 1'b1; fg_eop = 1'b0;
      #1 if (fg_ready) seen++;
    end
    fg_valid = 1'b0; fg_sop = 1'b0;
    check(seen == 0, "R7 fg_ready low in off mode", seen, 0);
  endtask

  task automatic collect(input int vx, input int vy, input int vm);
    int n, cyc, exp_d, x, y;
    string tag;
    n = 0; cyc = 0;
    while (n < NPIX) begin
      @(negedge clk);
      out_ready = (cyc % 3) != 1;
      cyc++;
      #1;
      if (out_valid && out_ready) begin
        x = n % BG_W; y = n / BG_W;
        exp_d = 8'h80 + n;
        if (vm == 1 && x >= vx && x < vx + FG_W && y >= vy && y < vy + FG_H)
          exp_d = 8'h40 + (y - vy) * FG_W + (x - vx);
        tag = (vm == 2) ? "R6 sink shows background" :
              (vm == 0) ? "R7 off shows background" :
              (vx + FG_W > BG_W || vy + FG_H > BG_H) ? "R9 clipped overlay" :
              "R5 overlay pixel / R8 latched / R10 no loss";
        check(out_data == PIX_W'(exp_d), tag, int'(out_data), exp_d);
        check(out_sop == (n == 0) && out_eop == (n == NPIX - 1),
              "R11 frame markers", {out_sop, out_eop}, {(n == 0), (n == NPIX - 1)});
        n++;
      end
    end
    @(negedge clk);
    out_ready = 1'b1;
    col_done = 1'b1;
  endtask

  task automatic mid_frame_ctl();
    logic [31:0] st;
    repeat (4) @(negedge clk);
    reg_read(1, st);
    check(st[0] == 1'b1, "R3 status running mid-frame", int'(st), 1);
    reg_write(0, 32'h0);
    reg_write(2, 32'd1);
    reg_write(3, 32'd1);
    reg_write(4, 32'd1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    checks = 0; errors = 0; col_done = 1'b0;
    rst_n = 1'b0; reg_cs = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    bg_valid = 1'b0; bg_data = '0; bg_sop = 1'b0; bg_eop = 1'b0;
    fg_valid = 1'b0; fg_data = '0; fg_sop = 1'b0; fg_eop = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!out_valid && !bg_ready && !fg_ready, "R1 outputs idle after reset",
          {out_valid, bg_ready, fg_ready}, 0);
    for (int a = 0; a < 8; a++) begin
      reg_read(a, rd);
      check(rd == 0, "R1 registers zero after reset", int'(rd), 0);
    end

    reg_write(0, 32'hFFFF_FFFE);
    reg_read(0, rd);
    check(rd == 0, "R2 control upper bits read zero", int'(rd), 0);
    reg_write(2, 32'd5);
    reg_read(2, rd);
    check(rd == 5, "R2 column offset readback", int'(rd), 5);
    reg_write(4, 32'd3);
    reg_read(4, rd);
    check(rd == 0, "R2 mode 3 stored as off", int'(rd), 0);
    reg_write(4, 32'd2);
    reg_read(4, rd);
    check(rd == 2, "R2 mode readback", int'(rd), 2);

    for (int v = 0; v < NV; v++) begin
      reg_write(2, 32'(VX[v]));
      reg_write(3, 32'(VY[v]));
      reg_write(4, 32'(VM[v]));
      col_done = 1'b0;
      reg_write(0, 32'h1);
      fork
        drive_bg();
        if (VM[v] != 0) drive_fg(); else watch_fg_off();
        collect(VX[v], VY[v], VM[v]);
        mid_frame_ctl();
      join
      repeat (3) @(negedge clk);
      reg_read(1, rd);
      check(rd == 0, "R3 status idle after frame with go cleared", int'(rd), 0);
    end

    begin
      int acc;
      acc = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        bg_valid = 1'b1; bg_sop = 1'b1; bg_data = 8'h11;
        #1 if (bg_ready) acc++;
      end
      @(negedge clk);
      bg_valid = 1'b0; bg_sop = 1'b0;
      check(acc == 0, "R4 no new frame while go is clear", acc, 0);
      check(!out_valid, "R4 no output while stopped", int'(out_valid), 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule